// File: doc/BRIEF.md
# ATA Device DMA Sector Buffer Port

This block is the data side of a storage target's DMA path. It holds one sector of 512 bytes and moves it to or from the host as 16-bit words. Each word puts its low byte at the even byte offset and its high byte at the next odd offset. The host side sees a request line (`dmarq`), an acknowledge input (`dmack`), and read and write strobes. The command engine sees a byte-wide port into the same buffer, a one-cycle "buffer drained" or "buffer filled" event, and a "transfer finished" event once the last sector of a command has moved.

Every DMA word must pass a strict check before it counts. The device must be selected, the host must acknowledge, the request must be up, the busy flag from the register block must be low, and the data-request flag must be high. The strobe must also match the direction of the running command. A read that fails any of these conditions returns all ones, and a write that fails is dropped. In both cases the word pointer stays where it is.

A new command always resets the word pointer, takes the request line down, and loads the sector count. A write command then raises the request at once. In both directions the command engine raises it again with `sector_ready` for each further sector, as long as sectors remain.

Top module: `ata_dma_port`

## Requirements
- R1: After reset, `dmarq`, `buf_empty`, `buf_full` and `xfer_done` are 0 and the word pointer is 0.
- R2: A host word is accepted only when `dev_sel`, `dmack` and `dmarq` are 1, `bsy` is 0, `drq` is 1 and `cmd_start` is 0. A rejected read drives `host_rdata` to 16'hFFFF, and a rejected write leaves the buffer unchanged. The word pointer does not move on a rejected access.
- R3: Host word k maps to buffer byte 2k for bits [7:0] and to byte 2k+1 for bits [15:8]. `med_rdata` returns the byte at `med_addr` combinationally, and `med_we` writes one byte.
- R4: In read direction, the clock edge that takes the 256th accepted read does three things: it returns the pointer to 0, drops `dmarq`, and makes `buf_empty` 1 for exactly the next cycle.
- R5: In write direction, the clock edge that takes the 256th accepted write drops `dmarq` and makes `buf_full` 1 for exactly the next cycle.
- R6: `cmd_start` with `cmd_wr_dma`=1 sets `dmarq` to 1 on the next edge.
- R7: `cmd_start` resets the pointer to 0 and loads the sector count. With `cmd_wr_dma`=0 it drives `dmarq` to 0. Host strobes in the same cycle as `cmd_start` are ignored.
- R8: Each buffer event decrements the remaining sector count. A `cmd_count` of 0 means 256 sectors. `xfer_done` is 1 together with the event that brings the count to 0.
- R9: `sector_ready` sets `dmarq` on the next edge only while the remaining count is non-zero. A buffer event in the same cycle takes precedence.
- R10: The direction is fixed by the last command. Read strobes during a write command are rejected, and write strobes during a read command are rejected.
- R11: `dmarq` changes only after `cmd_start`, after `sector_ready`, or at a buffer event.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| dev_sel | input | 1 | This device is the selected one |
| dmack | input | 1 | Host DMA acknowledge |
| bsy | input | 1 | Busy flag from register block |
| drq | input | 1 | Data-request flag from register block |
| cmd_start | input | 1 | A new command begins |
| cmd_wr_dma | input | 1 | The new command is a host-to-device DMA |
| cmd_count | input | 8 | Sector count of the new command (0 = 256) |
| sector_ready | input | 1 | Engine has the next sector ready |
| host_rd | input | 1 | Host DMA read strobe |
| host_wr | input | 1 | Host DMA write strobe |
| host_wdata | input | 16 | Host write word |
| host_rdata | output | 16 | Host read word, 16'hFFFF when rejected |
| dmarq | output | 1 | DMA request to host |
| buf_empty | output | 1 | One-cycle pulse: sector drained by host |
| buf_full | output | 1 | One-cycle pulse: sector filled by host |
| xfer_done | output | 1 | One-cycle pulse: last sector of command moved |
| med_we | input | 1 | Engine byte write |
| med_addr | input | 9 | Engine byte address |
| med_wdata | input | 8 | Engine byte write data |
| med_rdata | output | 8 | Engine byte read data |

## Verification
The hardest state to reach is the end of a 256-sector command started with a count of 0. Reaching it takes more than sixty-five thousand accepted writes, each sector re-armed by `sector_ready`. The bench gets there by streaming back-to-back writes and pulsing `sector_ready` between sectors. It then checks that `xfer_done` appears only on the final buffer event. The other difficult case is pointer reset in the middle of a sector. The bench aborts a partly written sector with a new command and reads the first bytes back through the engine port, which shows that the next word landed at offset 0.

// File: rtl/ata_dma_pkg.sv
package ata_dma_pkg;
  typedef enum logic {DIR_TO_HOST = 1'b0, DIR_FROM_HOST = 1'b1} xfer_dir_e;

  // Sector count code to sector total: a zero code stands for 2**w sectors.
  function automatic int unsigned sector_total(int unsigned code, int unsigned w);
    return (code == 0) ? (32'd1 << w) : code;
  endfunction

  // Byte lane selected by a byte address.
  function automatic int unsigned lane_of(int unsigned baddr, int unsigned lanes);
    return baddr % lanes;
  endfunction
endpackage

// File: rtl/ata_dma_gate.sv
module ata_dma_gate
  import ata_dma_pkg::*;
(
  input  logic      dev_sel,
  input  logic      dmack,
  input  logic      dmarq,
  input  logic      bsy,
  input  logic      drq,
  input  logic      cmd_start,
  input  xfer_dir_e dir,
  input  logic      host_rd,
  input  logic      host_wr,
  output logic      port_open,
  output logic      rd_ok,
  output logic      wr_ok
);
  always_comb begin
    port_open = dev_sel & dmack & dmarq & ~bsy & drq & ~cmd_start;
    rd_ok     = port_open & host_rd & (dir == DIR_TO_HOST);
    wr_ok     = port_open & host_wr & (dir == DIR_FROM_HOST);
  end
endmodule

// File: rtl/ata_dma_ptr.sv
module ata_dma_ptr #(
  parameter int WORDS = 256,
  localparam int PW = $clog2(WORDS)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          adv,
  output logic [PW-1:0] ptr,
  output logic          sect_end
);
  localparam logic [PW-1:0] LAST = PW'(WORDS - 1);

  assign sect_end = adv & (ptr == LAST);

  always_ff @(posedge clk) begin
    if (!rst_n || clr) ptr <= '0;
    else if (sect_end) ptr <= '0;
    else if (adv)      ptr <= ptr + 1'b1;
  end
endmodule

// File: rtl/ata_dma_buf.sv
module ata_dma_buf
  import ata_dma_pkg::*;
#(
  parameter int WORDS  = 256,
  parameter int WORD_W = 16,
  localparam int LANES = WORD_W / 8,
  localparam int PW    = $clog2(WORDS),
  localparam int AW    = $clog2(WORDS * LANES),
  localparam int LSW   = $clog2(LANES)
) (
  input  logic              clk,
  input  logic [PW-1:0]     host_idx,
  input  logic              host_we,
  input  logic [WORD_W-1:0] host_wdata,
  output logic [WORD_W-1:0] host_word,
  input  logic              med_we,
  input  logic [AW-1:0]     med_addr,
  input  logic [7:0]        med_wdata,
  output logic [7:0]        med_rdata
);
  logic [PW-1:0]  med_idx;
  logic [LSW-1:0] med_lane;
  logic [7:0]     med_lane_rd [LANES];

  assign med_idx  = med_addr[AW-1:LSW];
  assign med_lane = LSW'(lane_of(32'(med_addr), LANES));

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    logic [7:0] mem [WORDS];
    always_ff @(posedge clk) begin
      if (med_we && (med_lane == LSW'(l))) mem[med_idx] <= med_wdata;
      if (host_we) mem[host_idx] <= host_wdata[8*l +: 8];
    end
    assign host_word[8*l +: 8] = mem[host_idx];
    assign med_lane_rd[l]      = mem[med_idx];
  end

  assign med_rdata = med_lane_rd[med_lane];
endmodule

// File: rtl/ata_dma_port.sv
module ata_dma_port
  import ata_dma_pkg::*;
#(
  parameter int BUF_BYTES = 512,
  parameter int WORD_W    = 16,
  parameter int CNT_W     = 8,
  localparam int WORDS    = BUF_BYTES / (WORD_W / 8),
  localparam int PTR_W    = $clog2(WORDS),
  localparam int AW       = $clog2(BUF_BYTES),
  localparam int REM_W    = CNT_W + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              dev_sel,
  input  logic              dmack,
  input  logic              bsy,
  input  logic              drq,
  input  logic              cmd_start,
  input  logic              cmd_wr_dma,
  input  logic [CNT_W-1:0]  cmd_count,
  input  logic              sector_ready,
  input  logic              host_rd,
  input  logic              host_wr,
  input  logic [WORD_W-1:0] host_wdata,
  output logic [WORD_W-1:0] host_rdata,
  output logic              dmarq,
  output logic              buf_empty,
  output logic              buf_full,
  output logic              xfer_done,
  input  logic              med_we,
  input  logic [AW-1:0]     med_addr,
  input  logic [7:0]        med_wdata,
  output logic [7:0]        med_rdata
);
  xfer_dir_e         dir_q;
  logic [REM_W-1:0]  rem_q;
  logic              port_open, rd_ok, wr_ok, sect_end;
  logic [PTR_W-1:0]  word_ptr;
  logic [WORD_W-1:0] buf_word;

  ata_dma_gate u_gate (
    .dev_sel(dev_sel), .dmack(dmack), .dmarq(dmarq), .bsy(bsy), .drq(drq),
    .cmd_start(cmd_start), .dir(dir_q), .host_rd(host_rd), .host_wr(host_wr),
    .port_open(port_open), .rd_ok(rd_ok), .wr_ok(wr_ok)
  );

  ata_dma_ptr #(.WORDS(WORDS)) u_ptr (
    .clk(clk), .rst_n(rst_n), .clr(cmd_start), .adv(rd_ok | wr_ok),
    .ptr(word_ptr), .sect_end(sect_end)
  );

  ata_dma_buf #(.WORDS(WORDS), .WORD_W(WORD_W)) u_buf (
    .clk(clk), .host_idx(word_ptr), .host_we(wr_ok), .host_wdata(host_wdata),
    .host_word(buf_word), .med_we(med_we), .med_addr(med_addr),
    .med_wdata(med_wdata), .med_rdata(med_rdata)
  );

  assign host_rdata = rd_ok ? buf_word : '1;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      dir_q     <= DIR_TO_HOST;
      rem_q     <= '0;
      dmarq     <= 1'b0;
      buf_empty <= 1'b0;
      buf_full  <= 1'b0;
      xfer_done <= 1'b0;
    end else begin
      buf_empty <= 1'b0;
      buf_full  <= 1'b0;
      xfer_done <= 1'b0;
      if (cmd_start) begin
        dir_q <= cmd_wr_dma ? DIR_FROM_HOST : DIR_TO_HOST;
        rem_q <= REM_W'(sector_total(32'(cmd_count), CNT_W));
        dmarq <= cmd_wr_dma;
      end else if (sect_end) begin
        dmarq     <= 1'b0;
        rem_q     <= rem_q - 1'b1;
        buf_empty <= (dir_q == DIR_TO_HOST);
        buf_full  <= (dir_q == DIR_FROM_HOST);
        xfer_done <= (rem_q == REM_W'(1));
      end else if (sector_ready && rem_q != '0) begin
        dmarq <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/ata_dma_port_chk.sv
module ata_dma_port_chk #(
  parameter int PW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          cmd_start,
  input logic          cmd_wr_dma,
  input logic          sector_ready,
  input logic          host_rd,
  input logic          dmack,
  input logic [15:0]   host_rdata,
  input logic          dmarq,
  input logic          buf_empty,
  input logic          buf_full,
  input logic          xfer_done,
  input logic [PW-1:0] word_ptr
);
  AST_NOACK_READ_ONES: assert property (@(posedge clk) disable iff (!rst_n)
    (host_rd && !dmack) |-> host_rdata == 16'hFFFF); // R2
  AST_NOACK_PTR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!dmack && !cmd_start) |=> $stable(word_ptr)); // R2
  AST_EMPTY_DROPS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    buf_empty |-> !dmarq); // R4
  AST_FULL_DROPS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    buf_full |-> !dmarq); // R5
  AST_EVENTS_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
    !(buf_empty && buf_full)); // R5
  AST_WRSTART_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_start && cmd_wr_dma) |=> dmarq); // R6
  AST_RDSTART_NOREQ: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_start && !cmd_wr_dma) |=> !dmarq); // R7
  AST_START_PTR_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_start |=> word_ptr == '0); // R7
  AST_DONE_WITH_EVENT: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_done |-> (buf_empty || buf_full)); // R8
  AST_REQ_RISE_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(dmarq) |-> $past(cmd_start || sector_ready)); // R11
endmodule

bind ata_dma_port ata_dma_port_chk #(.PW(PTR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .cmd_start(cmd_start), .cmd_wr_dma(cmd_wr_dma),
  .sector_ready(sector_ready), .host_rd(host_rd), .dmack(dmack),
  .host_rdata(host_rdata), .dmarq(dmarq), .buf_empty(buf_empty),
  .buf_full(buf_full), .xfer_done(xfer_done), .word_ptr(word_ptr)
);

// File: tb/sim_ata_dma_port.sv
`timescale 1ns/1ps
module sim_ata_dma_port;
  logic clk = 0, rst_n = 0;
  logic dev_sel = 1, dmack = 0, bsy = 0, drq = 1;
  logic cmd_start = 0, cmd_wr_dma = 0, sector_ready = 0;
  logic [7:0] cmd_count = 0;
  logic host_rd = 0, host_wr = 0;
  logic [15:0] host_wdata = 0, host_rdata;
  logic dmarq, buf_empty, buf_full, xfer_done;
  logic med_we = 0;
  logic [8:0] med_addr = 0;
  logic [7:0] med_wdata = 0, med_rdata;

  ata_dma_port u0 (.*);

  always #2.5 clk = ~clk;

  int n_chk = 0, n_bad = 0, cyc = 0;
  bit live = 0;

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // ---------------- behavioural reference model ----------------
  byte unsigned m_mem [512];
  bit m_val [512];
  int m_ptr = 0, m_rem = 0;
  bit m_req = 0, m_wrdir = 0, m_e = 0, m_f = 0, m_d = 0;

  function automatic bit m_open();
    return dev_sel && dmack && m_req && !bsy && drq && !cmd_start;
  endfunction

  function automatic logic [15:0] m_rdata();
    if (m_open() && host_rd && !m_wrdir)
      return {m_mem[2*m_ptr+1], m_mem[2*m_ptr]};
    return 16'hFFFF;
  endfunction

  always @(posedge clk) begin
    bit acc;
    m_e = 0; m_f = 0; m_d = 0;
    if (!rst_n) begin
      m_ptr = 0; m_rem = 0; m_req = 0; m_wrdir = 0;
    end else begin
      if (med_we) begin m_mem[med_addr] = med_wdata; m_val[med_addr] = 1; end
      if (cmd_start) begin
        m_ptr = 0; m_wrdir = cmd_wr_dma; m_req = cmd_wr_dma;
        m_rem = (cmd_count == 0) ? 256 : int'(cmd_count);
      end else begin
        acc = m_open() && (m_wrdir ? host_wr : host_rd);
        if (acc && m_wrdir) begin
          m_mem[2*m_ptr] = host_wdata[7:0];    m_val[2*m_ptr] = 1;
          m_mem[2*m_ptr+1] = host_wdata[15:8]; m_val[2*m_ptr+1] = 1;
        end
        if (acc && m_ptr == 255) begin
          m_ptr = 0; m_req = 0; m_rem--;
          if (m_wrdir) m_f = 1; else m_e = 1;
          m_d = (m_rem == 0);
        end else begin
          if (acc) m_ptr++;
          if (sector_ready && m_rem != 0) m_req = 1;
        end
      end
    end
  end

  always @(negedge clk) if (live) begin
    chk("R11 dmarq", dmarq, m_req);
    chk("R2 host_rdata", host_rdata, m_rdata());
    chk("R4 buf_empty", buf_empty, m_e);
    chk("R5 buf_full", buf_full, m_f);
    chk("R8 xfer_done", xfer_done, m_d);
    if (m_val[med_addr]) chk("R3 med_rdata", med_rdata, m_mem[med_addr]);
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 190000) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog R1..all actual=%0d expected<190000", cyc);
      $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  // ---------------- stimulus helpers ----------------
  task automatic tick(); @(posedge clk); #1; endtask

  function automatic logic [7:0] pat(int s, int i);
    return 8'((i * 7 + s * 29 + 3) & 255);
  endfunction

  task automatic fill(int s);
    for (int i = 0; i < 512; i++) begin
      med_we = 1; med_addr = 9'(i); med_wdata = pat(s, i); tick();
    end
    med_we = 0;
  endtask

  task automatic start(bit wr, int cnt);
    cmd_start = 1; cmd_wr_dma = wr; cmd_count = 8'(cnt); tick();
    cmd_start = 0;
    chk(wr ? "R6 dmarq after write start" : "R7 dmarq after read start", dmarq, wr);
  endtask

  task automatic ready();
    sector_ready = 1; tick(); sector_ready = 0;
  endtask

  task automatic read_sector(int s);
    for (int k = 0; k < 256; k++) begin
      host_rd = 1;
      @(negedge clk);
      chk("R3 read word order", host_rdata, {pat(s, 2*k+1), pat(s, 2*k)});
      tick();
    end
    host_rd = 0;
  endtask

  task automatic write_words(int n, int s);
    for (int k = 0; k < n; k++) begin
      host_wr = 1; host_wdata = 16'((k + s) * 16'h0101 ^ 16'h5A3C); tick();
    end
    host_wr = 0;
  endtask

  task automatic peek(int a, logic [7:0] exp, string req);
    med_addr = 9'(a); #1;
    chk(req, med_rdata, exp);
  endtask

  initial begin
    repeat (3) tick();
    rst_n = 1;
    live = 1;
    chk("R1 dmarq at reset", dmarq, 0);
    chk("R1 buf_empty at reset", buf_empty, 0);
    chk("R1 xfer_done at reset", xfer_done, 0);

    // Read DMA, two sectors
    fill(1);
    start(0, 2);
    ready();
    chk("R9 dmarq after sector_ready", dmarq, 1);
    dmack = 0; host_rd = 1; @(negedge clk);
    chk("R2 read with dmack low", host_rdata, 16'hFFFF); tick();
    dmack = 1; bsy = 1; @(negedge clk);
    chk("R2 read with bsy", host_rdata, 16'hFFFF); tick();
    bsy = 0; drq = 0; @(negedge clk);
    chk("R2 read without drq", host_rdata, 16'hFFFF); tick();
    drq = 1; dev_sel = 0; @(negedge clk);
    chk("R2 read unselected", host_rdata, 16'hFFFF); tick();
    dev_sel = 1; host_rd = 0;
    read_sector(1);   // first word also proves pointer stayed at 0 (R1, R2)
    chk("R4 buf_empty after 256 reads", buf_empty, 1);
    chk("R4 dmarq dropped", dmarq, 0);
    chk("R8 not done after first sector", xfer_done, 0);
    tick();
    fill(2);
    ready();
    read_sector(2);
    chk("R8 xfer_done on last sector", xfer_done, 1);
    tick();
    ready();
    chk("R9 no request when count exhausted", dmarq, 0);

    // Write DMA, one sector
    start(1, 1);
    dmack = 0; host_wr = 1; host_wdata = 16'hAAAA; tick(); host_wr = 0;
    dmack = 1;
    host_rd = 1; @(negedge clk);
    chk("R10 read during write command", host_rdata, 16'hFFFF); tick();
    host_rd = 0;
    write_words(256, 0);
    chk("R5 buf_full after 256 writes", buf_full, 1);
    chk("R5 dmarq dropped", dmarq, 0);
    chk("R8 single-sector write done", xfer_done, 1);
    peek(0, 8'h3C, "R3 low byte at even offset");
    peek(1, 8'h5A, "R3 high byte at odd offset");
    peek(511, 8'(((255 * 16'h0101) ^ 16'h5A3C) >> 8), "R5 last byte written");

    // Pointer reset by new command mid-sector
    start(1, 1);
    write_words(10, 40);
    start(1, 1);
    host_wr = 1; host_wdata = 16'hBEEF; tick(); host_wr = 0;
    peek(0, 8'hEF, "R7 pointer back to 0");
    peek(1, 8'hBE, "R7 pointer back to 0 high");
    peek(2, 8'(((41 * 16'h0101) ^ 16'h5A3C) & 255), "R7 later words untouched");

    // Write strobe during read command, and strobe with cmd_start
    start(0, 1);
    fill(3);
    ready();
    host_wr = 1; host_wdata = 16'h1234; tick(); host_wr = 0;
    peek(0, pat(3, 0), "R10 write during read command discarded");
    cmd_start = 1; cmd_wr_dma = 0; cmd_count = 1; host_rd = 1; @(negedge clk);
    chk("R7 strobe with cmd_start ignored", host_rdata, 16'hFFFF); tick();
    cmd_start = 0; host_rd = 0;

    // Count 0 means 256 sectors
    start(1, 0);
    for (int s = 0; s < 256; s++) begin
      write_words(256, s);
      chk("R8 done only after sector 256", xfer_done, (s == 255));
      tick();
      ready();
      chk("R9 re-request while sectors remain", dmarq, (s != 255));
    end

    repeat (2) tick();
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule